// File: doc/BRIEF.md
# Interleaved SAR Phase Sequencer

This block times a time-interleaved converter built from sixteen identical successive-approximation sections that share one input clock. Each section walks a fixed sixteen-slot schedule: a reference-zero sample, an auto-zero comparison, an auto-calibration comparison, an input sample, nine bit trials, two idle settle slots and a transfer slot. The schedules of neighbouring sections are offset by one clock, so that exactly one section takes the input on every cycle.

Besides the per-section phase strobes, the block holds each section's 9-bit successive-approximation register. A digital comparator decision for each section arrives on `cmp_i` and resolves one bit per trial slot, MSB first. A power-up timer raises a calibration-done flag once enough clock cycles have passed for the closed-loop calibration to settle. The zero and calibration strobes keep running after that point, so calibration is maintained for as long as the clock runs.

Top module: `interleaved_sar_sequencer`

## Requirements
- R1: While `rst_ni` is low, every code is zero, `cal_done_o` is low and section k sits in slot k+1 (slots numbered 1 to 16), so section 3 shows the input-sample strobe.
- R2: For a section in slot 1, 2, 3, 4, 5..13 or 16, exactly the strobe zero, az, calc, samp, trial or xfer respectively is high; in slots 14 and 15 no strobe of that section is high.
- R3: Every rising edge of `clk_i` moves every section to the next slot, slot 16 wrapping to slot 1.
- R4: Exactly one bit of `samp_o` is high in every cycle, and the section that samples on one cycle is followed on the next cycle by the section with index one lower (section 0 followed by section 15).
- R5: The edge that ends a section's sample slot loads its code (bits [9k+8:9k] of `code_o`) with 0x100, i.e. only the MSB tentatively set.
- R6: The edge that ends trial slot 5+j (j = 0..8, bit b = 8-j) writes bit b with that section's `cmp_i` bit and, when b > 0, sets bit b-1 tentatively; the other bits keep their values.
- R7: A section's code holds from the end of slot 13 through slots 14, 15, 16 and 1 to 4; `cmp_i` has no effect outside trial slots.
- R8: `cal_done_o` goes high after `CAL_CYCLES` (default 10000) rising edges following reset release, not one edge earlier, and then stays high until reset.
- R9: Zero, auto-zero and calibration strobes continue with the same schedule after `cal_done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock; all slots advance on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_i | input | 16 | Comparator decision per section, bit k for section k |
| zero_o | output | 16 | Reference-zero sample strobe per section |
| az_o | output | 16 | Auto-zero compare strobe per section |
| calc_o | output | 16 | Auto-calibration compare strobe per section |
| samp_o | output | 16 | Input sample strobe per section |
| trial_o | output | 16 | Bit-trial strobe per section |
| xfer_o | output | 16 | Result transfer strobe per section |
| code_o | output | 144 | Trial code per section, section k in bits [9k+8:9k] |
| cal_done_o | output | 1 | Power-up calibration interval complete |

## Verification
Assertions watch, on every cycle, that one section samples per clock and that the sample slot hands over to the next-lower section. They also check that a sample is followed by a trial and a transfer by a zero sample, that a code loads its MSB after sampling and takes the comparator bit after each trial, that it holds outside these slots, and that the done flag never drops. Only the bench scenarios can show that a full conversion lands on the intended 9-bit value for all-zero, all-one, alternating and mixed targets in every section, that the slot pattern matches the absolute reset position, and that the done flag rises on exactly the right edge, including after a reset in mid-run.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef struct packed {
    logic zero;
    logic az;
    logic calc;
    logic samp;
    logic trial;
    logic xfer;
  } phase_t;

  localparam int SLOT_ZERO = 0;
  localparam int SLOT_AZ   = 1;
  localparam int SLOT_CALC = 2;
  localparam int SLOT_SAMP = 3;
  localparam int SLOT_TRIAL0 = 4;
endpackage

// File: rtl/sar_phase_ring.sv
module sar_phase_ring #(
  parameter int N_SEC = 16,
  localparam int SW = $clog2(N_SEC)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  output logic [N_SEC-1:0][SW-1:0]  slot_o
);
  logic [SW-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) base_q <= '0;
    else if (base_q == SW'(N_SEC-1)) base_q <= '0;
    else base_q <= base_q + SW'(1);
  end

  // section k runs k slots ahead of section 0
  for (genvar k = 0; k < N_SEC; k++) begin : g_slot
    logic [SW:0] sum;
    assign sum = {1'b0, base_q} + (SW+1)'(k);
    assign slot_o[k] = (sum >= (SW+1)'(N_SEC)) ? SW'(sum - (SW+1)'(N_SEC)) : SW'(sum);
  end
endmodule

// File: rtl/sar_phase_decode.sv
module sar_phase_decode
  import sar_seq_pkg::*;
#(
  parameter int N_SEC = 16,
  parameter int SAR_W = 9,
  localparam int SW = $clog2(N_SEC),
  localparam int TRIAL_HI = SLOT_TRIAL0 + SAR_W - 1,
  localparam int SLOT_XFER = N_SEC - 1
) (
  input  logic [SW-1:0] slot_i,
  output phase_t        ph_o
);
  always_comb begin
    ph_o       = '0;
    ph_o.zero  = (slot_i == SW'(SLOT_ZERO));
    ph_o.az    = (slot_i == SW'(SLOT_AZ));
    ph_o.calc  = (slot_i == SW'(SLOT_CALC));
    ph_o.samp  = (slot_i == SW'(SLOT_SAMP));
    ph_o.trial = (slot_i >= SW'(SLOT_TRIAL0)) && (slot_i <= SW'(TRIAL_HI));
    ph_o.xfer  = (slot_i == SW'(SLOT_XFER));
  end
endmodule

// File: rtl/sar_section_reg.sv
module sar_section_reg
  import sar_seq_pkg::*;
#(
  parameter int N_SEC = 16,
  parameter int SAR_W = 9,
  localparam int SW = $clog2(N_SEC),
  localparam int BW = $clog2(SAR_W),
  localparam int TRIAL_HI = SLOT_TRIAL0 + SAR_W - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SW-1:0]    slot_i,
  input  phase_t           ph_i,
  input  logic             cmp_i,
  output logic [SAR_W-1:0] code_o
);
  logic [SAR_W-1:0] code_q, code_d;
  logic [BW-1:0]    bit_idx;

  // slot 5 resolves the MSB, last trial slot the LSB
  assign bit_idx = BW'(TRIAL_HI - int'(slot_i));

  always_comb begin
    code_d = code_q;
    if (ph_i.samp) begin
      code_d = '0;
      code_d[SAR_W-1] = 1'b1;
    end else if (ph_i.trial) begin
      for (int b = 0; b < SAR_W; b++) begin
        if (BW'(b) == bit_idx) code_d[b] = cmp_i;
        if (BW'(b + 1) == bit_idx) code_d[b] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= '0;
    else code_q <= code_d;
  end

  assign code_o = code_q;

  // R5
  msb_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_i.samp |=> (code_o == SAR_W'(1) << (SAR_W-1)));
  // R6
  trial_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_i.trial |=> (code_o[$past(bit_idx)] == $past(cmp_i)));
  // R7
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ph_i.samp && !ph_i.trial) |=> $stable(code_o));
endmodule

// File: rtl/sar_cal_timer.sv
module sar_cal_timer #(
  parameter int CAL_CYCLES = 10000,
  localparam int CW = $clog2(CAL_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic done_o
);
  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (!done_q) cnt_q <= cnt_q + CW'(1);
      if (cnt_q == CW'(CAL_CYCLES - 1)) done_q <= 1'b1;
    end
  end

  assign done_o = done_q;

  // R8
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  // R8
  done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(cnt_q) == CW'(CAL_CYCLES - 1)));
endmodule

// File: rtl/interleaved_sar_sequencer.sv
module interleaved_sar_sequencer
  import sar_seq_pkg::*;
#(
  parameter int N_SEC      = 16,
  parameter int SAR_W      = 9,
  parameter int CAL_CYCLES = 10000,
  localparam int SW = $clog2(N_SEC)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_SEC-1:0]         cmp_i,
  output logic [N_SEC-1:0]         zero_o,
  output logic [N_SEC-1:0]         az_o,
  output logic [N_SEC-1:0]         calc_o,
  output logic [N_SEC-1:0]         samp_o,
  output logic [N_SEC-1:0]         trial_o,
  output logic [N_SEC-1:0]         xfer_o,
  output logic [N_SEC*SAR_W-1:0]   code_o,
  output logic                     cal_done_o
);
  logic [N_SEC-1:0][SW-1:0] slot;

  sar_phase_ring #(.N_SEC(N_SEC)) u_ring (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .slot_o(slot)
  );

  for (genvar k = 0; k < N_SEC; k++) begin : g_sec
    phase_t ph;

    sar_phase_decode #(.N_SEC(N_SEC), .SAR_W(SAR_W)) u_dec (
      .slot_i(slot[k]),
      .ph_o  (ph)
    );

    sar_section_reg #(.N_SEC(N_SEC), .SAR_W(SAR_W)) u_sar (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .slot_i(slot[k]),
      .ph_i  (ph),
      .cmp_i (cmp_i[k]),
      .code_o(code_o[k*SAR_W +: SAR_W])
    );

    assign zero_o[k]  = ph.zero;
    assign az_o[k]    = ph.az;
    assign calc_o[k]  = ph.calc;
    assign samp_o[k]  = ph.samp;
    assign trial_o[k] = ph.trial;
    assign xfer_o[k]  = ph.xfer;

    // R4
    samp_handover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      samp_o[k] |=> samp_o[(k + N_SEC - 1) % N_SEC]);
    // R3
    samp_to_trial_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      samp_o[k] |=> trial_o[k]);
    // R3
    xfer_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      xfer_o[k] |=> zero_o[k]);
  end

  sar_cal_timer #(.CAL_CYCLES(CAL_CYCLES)) u_cal (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .done_o(cal_done_o)
  );

  // R4
  one_sampler_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(samp_o) == 1);
  // R9
  cal_keeps_running_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_done_o |-> ($countones(calc_o) == 1 && $countones(zero_o) == 1));
endmodule

// File: tb/interleaved_sar_sequencer_tb.sv
module interleaved_sar_sequencer_tb;
  localparam int N   = 16;
  localparam int W   = 9;
  localparam int CAL = 10000;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [N-1:0]    cmp_i = '0;
  logic [N-1:0]    zero_o, az_o, calc_o, samp_o, trial_o, xfer_o;
  logic [N*W-1:0]  code_o;
  logic            cal_done_o;

  int checks = 0;
  int errors = 0;
  int e = 0;
  bit finished = 1'b0;
  logic [W-1:0] tgt [N];
  logic [W-1:0] prv [N];
  bit           started [N];
  int           rnd [N];

  interleaved_sar_sequencer #(.N_SEC(N), .SAR_W(W), .CAL_CYCLES(CAL)) u_dut (
    .clk_i, .rst_ni, .cmp_i, .zero_o, .az_o, .calc_o, .samp_o,
    .trial_o, .xfer_o, .code_o, .cal_done_o
  );

  always #10 clk_i = ~clk_i;

  function automatic logic [W-1:0] pick(int r, int k);
    if (r == 0) return (k % 2 == 1) ? 9'h1FF : 9'h000;
    if (r == 1) return (k % 2 == 1) ? 9'h000 : 9'h1FF;
    if (r == 2) return (k % 4 < 2) ? 9'h155 : 9'h0AA;
    return 9'((r * 149 + k * 71 + 3) % 512);
  endfunction

  task automatic report;
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp_v, int k);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s sec %0d edge %0d actual %h expected %h", req, k, e, act, exp_v);
    end
  endtask

  task automatic init_state;
    e = 0;
    for (int k = 0; k < N; k++) begin
      prv[k] = '0;
      started[k] = (k <= 3);
      tgt[k] = pick(rnd[k], k);
    end
  endtask

  // checks at the current negedge, then sets cmp_i for the coming edge
  task automatic step;
    for (int k = 0; k < N; k++) begin
      int s = (e + k) % N;
      logic [5:0] exp_ph, act_ph;
      logic [W-1:0] exp_c, act_c;
      exp_ph = {s == 0, s == 1, s == 2, s == 3, (s >= 4 && s <= 12), s == 15};
      act_ph = {zero_o[k], az_o[k], calc_o[k], samp_o[k], trial_o[k], xfer_o[k]};
      // R2 R3 R9 slot pattern
      chk(act_ph == exp_ph, "R2/R3/R9", W'(act_ph), W'(exp_ph), k);
      act_c = code_o[k*W +: W];
      if (started[k]) begin
        if (s >= 4 && s <= 12) begin
          int b = 12 - s;
          exp_c = ((tgt[k] >> (b + 1)) << (b + 1)) | W'(1 << b);
          chk(act_c == exp_c, (s == 4) ? "R5" : "R6", act_c, exp_c, k);
        end else if (s >= 13) begin
          exp_c = tgt[k];
          chk(act_c == exp_c, (s == 13) ? "R6" : "R7", act_c, exp_c, k);
        end else begin
          exp_c = prv[k];
          chk(act_c == exp_c, "R7", act_c, exp_c, k);
        end
      end
      if (s == 15) begin
        prv[k] = tgt[k];
        rnd[k]++;
        tgt[k] = pick(rnd[k], k);
      end
      if (s == 3) started[k] = 1'b1;
      // R7: comparator held high outside trials must not disturb codes
      cmp_i[k] = (s >= 4 && s <= 12) ? tgt[k][12 - s] : 1'b1;
    end
    // R4
    chk($countones(samp_o) == 1, "R4", W'($countones(samp_o)), W'(1), -1);
    // R8
    chk(cal_done_o == (e >= CAL), "R8", W'(cal_done_o), W'(e >= CAL), -1);
  endtask

  task automatic run(int n);
    repeat (n) begin
      step();
      @(posedge clk_i);
      e++;
      @(negedge clk_i);
    end
  endtask

  task automatic reset_checks;
    for (int k = 0; k < N; k++) begin
      // R1
      chk(code_o[k*W +: W] == '0, "R1", code_o[k*W +: W], '0, k);
      chk(samp_o[k] == (k == 3), "R1", W'(samp_o[k]), W'(k == 3), k);
    end
    chk(cal_done_o == 1'b0, "R1", W'(cal_done_o), '0, -1);
  endtask

  initial begin
    #(20 * 50000);
    checks++;
    errors++;
    $display("FAIL watchdog expired at edge %0d", e);
    report();
  end

  initial begin
    for (int k = 0; k < N; k++) rnd[k] = 0;
    init_state();
    repeat (3) @(negedge clk_i);
    reset_checks();
    rst_ni = 1'b1;
    run(CAL + 60);
    // asynchronous reset mid-run, outputs must return at once
    rst_ni = 1'b0;
    #2;
    reset_checks();
    @(negedge clk_i);
    reset_checks();
    init_state();
    rst_ni = 1'b1;
    run(70);
    report();
  end
endmodule